// File: doc/BRIEF.md
# Complement-Checked Secure RAM Controller

This block is a bus slave in front of a 128-word by 32-bit RAM held inside the block. A request carries a byte address, write data, an access size (byte, half-word or word) and read or write strobes. The response (read data and an error flag) comes back on the next clock cycle.

With the protected mode input low, the whole physical array is plain memory: every size of access works and byte enables mask the write. With the protected mode input high, each data byte is stored beside its bitwise inverse. Every protected read checks that each fetched pair really complements, and it flags an error when a pair does not match. Only the lower half of the logical space holds data, the upper half is reserved, and word-size accesses are neutralised.

Top module: `secure_ram_ctrl`

## Requirements
- R1: While reset is low, and on the first cycle after it is released, rsp_valid and rsp_err are 0 and rsp_rdata is 0.
- R2: Every cycle with req_rd or req_wr high produces exactly one cycle with rsp_valid high on the following cycle. Back-to-back requests are served each cycle, and a read issued the cycle after a write returns the newly written data. Read data is lane-aligned: a byte at address A appears in bits [8*A[1:0]+7 : 8*A[1:0]], and a half-word appears in lanes 2*A[1] and 2*A[1]+1. Lanes not covered are zero. Write responses return zero data. When both strobes are high, the request is a write.
- R3: With protect_en low, byte addresses 0..511 map to physical word A[8:2]. Writes update only the lanes covered by the size. Reads return those lanes.
- R4: With protect_en high, a byte write at logical address B (B < 256) stores the data byte into physical word B[7:1]. The data goes to lane 0 and its inverse to lane 1 when B is even. The data goes to lane 2 and its inverse to lane 3 when B is odd. A half-word write at even B fills all four lanes of that word: the low byte in lanes 0/1 and the high byte in lanes 2/3.
- R5: With protect_en high, a read whose pair or pairs are exact complements returns the data byte or bytes with rsp_err low.
- R6: A protected read of a byte whose stored pair is not an exact complement raises rsp_err. Whenever rsp_err is high, rsp_rdata is 0.
- R7: With protect_en high, a word-size write to the data region changes nothing. A word-size read there returns 0 with rsp_err low.
- R8: With protect_en high, any read or write with address bit 8 set (the reserved half) raises rsp_err and does not change memory.
- R9: A half-word access with A[0] set, in either mode, raises rsp_err and has no effect. So does a word access with A[1:0] not zero when protect_en is low.
- R10: A protected half-word read checks both byte pairs. A mismatch in either pair raises rsp_err.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| protect_en | input | 1 | 1 selects complement-protected mode |
| req_rd | input | 1 | Read strobe |
| req_wr | input | 1 | Write strobe (wins over req_rd) |
| req_addr | input | 9 | Byte address |
| req_size | input | 2 | 0 byte, 1 half-word, 2 word (3 treated as word) |
| req_wdata | input | 32 | Lane-aligned write data |
| rsp_valid | output | 1 | Response present this cycle |
| rsp_rdata | output | 32 | Lane-aligned read data |
| rsp_err | output | 1 | Bus error for the request of the previous cycle |

## Verification
A response can emerge in the same cycle that a new request is taken, and the two can touch the same physical word. The test sends a protected write, then on the very next cycle a read of that word. The read must return the new pair, while the write response sitting in the same cycle must carry zero data. The test also corrupts a complement lane in plain mode and then reads it protected on the next cycle. The error, the zeroed data and an untouched neighbouring byte are all checked at the response port one cycle later.

// File: rtl/secure_ram_pkg.sv
// Shared types for the complement-checked RAM controller.
package secure_ram_pkg;

    // Access size encoding carried on req_size.
    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_RSVD = 2'd3
    } acc_size_e;

    localparam int unsigned LANE_W = 8;
    localparam int unsigned LANES  = 4;
    localparam int unsigned DATA_W = LANE_W * LANES;

endpackage

// File: rtl/secure_ram_decode.sv
// Request decoder. It turns a byte address, a size and the mode into a
// physical word index, lane enables and the physical write word. It also
// flags decode errors (reserved half, misalignment) and protected-mode word
// accesses that must be neutralised.
// Assumes a 32-bit word of four byte lanes. The address width covers
// WORDS*4 bytes.
module secure_ram_decode
    import secure_ram_pkg::*;
#(
    parameter int unsigned WORDS  = 128,
    localparam int unsigned ADDR_W = $clog2(WORDS * LANES),
    localparam int unsigned IDX_W  = $clog2(WORDS)
) (
    input  logic              protect,
    input  acc_size_e         size,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [IDX_W-1:0]  idx,
    output logic [LANES-1:0]  lane_en,
    output logic [DATA_W-1:0] phys_wdata,
    output logic              dec_err,
    output logic              word_null
);

    logic [LANE_W-1:0] byte_in;
    logic [LANE_W-1:0] half_lo;
    logic [LANE_W-1:0] half_hi;

    // Pick the byte or half-word from its bus lane.
    always_comb begin
        byte_in = wdata[{addr[1:0], 3'b000} +: LANE_W];
        half_lo = addr[1] ? wdata[23:16] : wdata[7:0];
        half_hi = addr[1] ? wdata[31:24] : wdata[15:8];
    end

    // Decode the mode, size and address into physical controls.
    always_comb begin
        idx        = '0;
        lane_en    = '0;
        phys_wdata = '0;
        dec_err    = 1'b0;
        word_null  = 1'b0;
        if (!protect) begin
            idx        = addr[ADDR_W-1:2];
            phys_wdata = wdata;
            unique case (size)
                SZ_BYTE: lane_en = 4'b0001 << addr[1:0];
                SZ_HALF: begin
                    if (addr[0]) dec_err = 1'b1;
                    else         lane_en = addr[1] ? 4'b1100 : 4'b0011;
                end
                default: begin
                    if (addr[1:0] != 2'b00) dec_err = 1'b1;
                    else                    lane_en = 4'b1111;
                end
            endcase
        end else begin
            idx = addr[ADDR_W-2:1];
            if (addr[ADDR_W-1]) begin
                dec_err = 1'b1;
            end else begin
                unique case (size)
                    SZ_BYTE: begin
                        lane_en    = addr[0] ? 4'b1100 : 4'b0011;
                        phys_wdata = {2{~byte_in, byte_in}};
                    end
                    SZ_HALF: begin
                        if (addr[0]) begin
                            dec_err = 1'b1;
                        end else begin
                            lane_en    = 4'b1111;
                            phys_wdata = {~half_hi, half_hi, ~half_lo, half_lo};
                        end
                    end
                    default: word_null = 1'b1;
                endcase
            end
        end
    end

endmodule

// File: rtl/secure_ram_array.sv
// Physical storage: WORDS x 32 bits with per-lane write enables and a
// registered read port. Contents are not reset (a RAM macro has no reset).
module secure_ram_array
    import secure_ram_pkg::*;
#(
    parameter int unsigned WORDS = 128,
    localparam int unsigned IDX_W = $clog2(WORDS)
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [LANES-1:0]  lane_en,
    input  logic [IDX_W-1:0]  idx,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] mem [WORDS];

    // Lane-masked write and read-before-write registered fetch.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            for (int l = 0; l < int'(LANES); l++) begin
                if (lane_en[l]) mem[idx][l*LANE_W +: LANE_W] <= wdata[l*LANE_W +: LANE_W];
            end
        end
        rdata <= mem[idx];
    end

endmodule

// File: rtl/secure_ram_resp.sv
// Response former. It extracts the addressed lanes from the fetched word,
// checks the complement pairs in protected mode, and forces the data to zero
// on any error, on writes and on neutralised word reads.
// Assumes the request fields it gets are those registered with the fetch.
module secure_ram_resp
    import secure_ram_pkg::*;
(
    input  logic              protect,
    input  logic              is_rd,
    input  acc_size_e         size,
    input  logic [1:0]        lane,
    input  logic              dec_err,
    input  logic              word_null,
    input  logic [DATA_W-1:0] raw,
    output logic [DATA_W-1:0] rdata,
    output logic              err
);

    logic [DATA_W-1:0] data;
    logic              pair_bad;
    logic [LANE_W-1:0] sel;
    logic [LANE_W-1:0] inv;

    // Lane extraction and complement check for the addressed size.
    always_comb begin
        data     = '0;
        pair_bad = 1'b0;
        sel      = lane[0] ? raw[23:16] : raw[7:0];
        inv      = lane[0] ? raw[31:24] : raw[15:8];
        if (!protect) begin
            unique case (size)
                SZ_BYTE: data = raw & (32'h0000_00FF << {lane, 3'b000});
                SZ_HALF: data = raw & (lane[1] ? 32'hFFFF_0000 : 32'h0000_FFFF);
                default: data = raw;
            endcase
        end else begin
            unique case (size)
                SZ_BYTE: begin
                    pair_bad = (sel != ~inv);
                    data     = DATA_W'(sel) << {lane, 3'b000};
                end
                SZ_HALF: begin
                    pair_bad = (raw[7:0] != ~raw[15:8]) || (raw[23:16] != ~raw[31:24]);
                    data     = DATA_W'({raw[23:16], raw[7:0]}) << {lane[1], 4'b0000};
                end
                default: data = '0;
            endcase
        end
    end

    // Merge the error sources and gate the data.
    always_comb begin
        err   = dec_err || (is_rd && !word_null && pair_bad);
        rdata = (is_rd && !err && !word_null) ? data : '0;
    end

endmodule

// File: rtl/secure_ram_ctrl.sv
// Top of the complement-checked RAM controller. It accepts one request per
// cycle and answers on the next cycle. Protected mode stores each byte with
// its inverse and checks the pair on reads; plain mode passes through.
// Assumes the requester drives at most one request per cycle; a write wins
// if both strobes are high.
module secure_ram_ctrl
    import secure_ram_pkg::*;
#(
    parameter int unsigned WORDS  = 128,
    localparam int unsigned ADDR_W = $clog2(WORDS * LANES),
    localparam int unsigned IDX_W  = $clog2(WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              protect_en,
    input  logic              req_rd,
    input  logic              req_wr,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_size,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              rsp_err
);

    acc_size_e         size;
    logic [IDX_W-1:0]  idx;
    logic [LANES-1:0]  lane_en;
    logic [DATA_W-1:0] phys_wdata;
    logic [DATA_W-1:0] raw;
    logic              dec_err;
    logic              word_null;
    logic              do_wr;
    logic              do_rd;

    logic              s_vld;
    logic              s_rd;
    logic              s_protect;
    acc_size_e         s_size;
    logic [1:0]        s_lane;
    logic              s_dec_err;
    logic              s_null;

    // Size cast and strobe arbitration.
    always_comb begin
        size  = acc_size_e'(req_size);
        do_rd = req_rd && !req_wr;
        do_wr = req_wr && !dec_err && !word_null;
    end

    secure_ram_decode #(.WORDS(WORDS)) u_decode (
        .protect    (protect_en),
        .size       (size),
        .addr       (req_addr),
        .wdata      (req_wdata),
        .idx        (idx),
        .lane_en    (lane_en),
        .phys_wdata (phys_wdata),
        .dec_err    (dec_err),
        .word_null  (word_null)
    );

    secure_ram_array #(.WORDS(WORDS)) u_array (
        .clk     (clk),
        .wr_en   (do_wr),
        .lane_en (lane_en),
        .idx     (idx),
        .wdata   (phys_wdata),
        .rdata   (raw)
    );

    // Register the request attributes alongside the RAM fetch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_vld     <= 1'b0;
            s_rd      <= 1'b0;
            s_protect <= 1'b0;
            s_size    <= SZ_BYTE;
            s_lane    <= '0;
            s_dec_err <= 1'b0;
            s_null    <= 1'b0;
        end else begin
            s_vld     <= req_rd || req_wr;
            s_rd      <= do_rd;
            s_protect <= protect_en;
            s_size    <= size;
            s_lane    <= req_addr[1:0];
            s_dec_err <= (req_rd || req_wr) && dec_err;
            s_null    <= word_null;
        end
    end

    logic [DATA_W-1:0] f_rdata;
    logic              f_err;

    secure_ram_resp u_resp (
        .protect   (s_protect),
        .is_rd     (s_rd),
        .size      (s_size),
        .lane      (s_lane),
        .dec_err   (s_dec_err),
        .word_null (s_null),
        .raw       (raw),
        .rdata     (f_rdata),
        .err       (f_err)
    );

    // Drive the response only while a response is due.
    always_comb begin
        rsp_valid = s_vld;
        rsp_err   = s_vld && f_err;
        rsp_rdata = s_vld ? f_rdata : '0;
    end

endmodule

// File: rtl/secure_ram_ctrl_chk.sv
// Property checker for secure_ram_ctrl, attached by bind. It observes
// ports only.
module secure_ram_ctrl_chk #(
    parameter int unsigned ADDR_W = 9
) (
    input logic              clk,
    input logic              rst_n,
    input logic              protect_en,
    input logic              req_rd,
    input logic              req_wr,
    input logic [ADDR_W-1:0] req_addr,
    input logic [1:0]        req_size,
    input logic [31:0]       req_wdata,
    input logic              rsp_valid,
    input logic [31:0]       rsp_rdata,
    input logic              rsp_err
);

    // R1
    reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (!rsp_valid && !rsp_err && rsp_rdata == 32'h0));

    // R2
    one_rsp_per_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (rsp_valid == $past(req_rd || req_wr)));

    // R2
    quiet_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> (!rsp_err && rsp_rdata == 32'h0));

    // R6
    err_zero_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> (rsp_rdata == 32'h0));

    // R7
    word_read_null_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n && protect_en && req_rd && !req_wr && req_size == 2'd2 && !req_addr[ADDR_W-1])
        |-> (rsp_valid && !rsp_err && rsp_rdata == 32'h0));

    // R8
    reserved_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n && protect_en && (req_rd || req_wr) && req_addr[ADDR_W-1])
        |-> (rsp_valid && rsp_err));

    // R9
    half_misalign_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n && (req_rd || req_wr) && req_size == 2'd1 && req_addr[0])
        |-> (rsp_valid && rsp_err));

endmodule

bind secure_ram_ctrl secure_ram_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/secure_ram_ctrl_test.sv
// Scoreboard bench: the driver queues the expected response of each request,
// and a monitor pops and compares it when rsp_valid shows up.
module secure_ram_ctrl_test;

    typedef struct {
        logic [31:0] rdata;
        logic        err;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        protect_en;
    logic        req_rd;
    logic        req_wr;
    logic [8:0]  req_addr;
    logic [1:0]  req_size;
    logic [31:0] req_wdata;
    logic        rsp_valid;
    logic [31:0] rsp_rdata;
    logic        rsp_err;

    exp_t exp_q[$];
    int   n_cmp = 0;
    int   n_bad = 0;

    always #5 clk = ~clk;

    secure_ram_ctrl uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .protect_en (protect_en),
        .req_rd     (req_rd),
        .req_wr     (req_wr),
        .req_addr   (req_addr),
        .req_size   (req_size),
        .req_wdata  (req_wdata),
        .rsp_valid  (rsp_valid),
        .rsp_rdata  (rsp_rdata),
        .rsp_err    (rsp_err)
    );

    task automatic report();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    task automatic issue(input logic wr, input logic sil, input logic [8:0] a,
                         input logic [1:0] sz, input logic [31:0] wd,
                         input logic [31:0] erd, input logic eerr, input string tag);
        exp_t e;
        @(negedge clk);
        protect_en = sil;
        req_wr     = wr;
        req_rd     = !wr;
        req_addr   = a;
        req_size   = sz;
        req_wdata  = wd;
        e.rdata = erd;
        e.err   = eerr;
        e.tag   = tag;
        exp_q.push_back(e);
    endtask

    task automatic wr(input logic sil, input logic [8:0] a, input logic [1:0] sz,
                      input logic [31:0] wd, input logic eerr, input string tag);
        issue(1'b1, sil, a, sz, wd, 32'h0, eerr, tag);
    endtask

    task automatic rd(input logic sil, input logic [8:0] a, input logic [1:0] sz,
                      input logic [31:0] erd, input logic eerr, input string tag);
        issue(1'b0, sil, a, sz, 32'h0, erd, eerr, tag);
    endtask

    task automatic idle();
        @(negedge clk);
        req_rd = 1'b0;
        req_wr = 1'b0;
    endtask

    // Monitor: compare each response with the oldest expected item.
    always @(negedge clk) begin
        if (rst_n === 1'b1 && rsp_valid === 1'b1) begin
            n_cmp++;
            if (exp_q.size() == 0) begin
                n_bad++;
                $display("FAIL R2: unexpected response rdata=%h err=%b expected no response",
                         rsp_rdata, rsp_err);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                if (rsp_rdata !== e.rdata || rsp_err !== e.err) begin
                    n_bad++;
                    $display("FAIL %s: rdata=%h err=%b expected rdata=%h err=%b",
                             e.tag, rsp_rdata, rsp_err, e.rdata, e.err);
                end
            end
        end
    end

    // Watchdog: a hung run is a failure.
    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: run did not finish, expected completion");
        report();
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        protect_en = 1'b0;
        req_rd = 1'b0;
        req_wr = 1'b0;
        req_addr = '0;
        req_size = '0;
        req_wdata = '0;
        repeat (4) @(negedge clk);
        n_cmp++;
        if (rsp_valid !== 1'b0 || rsp_err !== 1'b0 || rsp_rdata !== 32'h0) begin
            n_bad++;
            $display("FAIL R1: valid=%b err=%b rdata=%h expected 0 0 00000000",
                     rsp_valid, rsp_err, rsp_rdata);
        end
        rst_n = 1'b1;
        @(negedge clk);
        n_cmp++;
        if (rsp_valid !== 1'b0 || rsp_err !== 1'b0 || rsp_rdata !== 32'h0) begin
            n_bad++;
            $display("FAIL R1: after release valid=%b err=%b rdata=%h expected 0 0 00000000",
                     rsp_valid, rsp_err, rsp_rdata);
        end

        // R3: plain mode, all sizes with lane masking
        wr(0, 9'h010, 2'd2, 32'hA1B2C3D4, 0, "R3 word write");
        rd(0, 9'h010, 2'd2, 32'hA1B2C3D4, 0, "R3 word read");
        wr(0, 9'h011, 2'd0, 32'h00005E00, 0, "R3 byte write");
        rd(0, 9'h010, 2'd2, 32'hA1B25ED4, 0, "R3 byte merge");
        rd(0, 9'h013, 2'd0, 32'hA1000000, 0, "R3 byte read lane3");
        wr(0, 9'h012, 2'd1, 32'h77880000, 0, "R3 half write");
        rd(0, 9'h010, 2'd2, 32'h77885ED4, 0, "R3 half merge");
        rd(0, 9'h012, 2'd1, 32'h77880000, 0, "R3 half read");
        rd(0, 9'h010, 2'd0, 32'h000000D4, 0, "R3 byte read lane0");
        // R9: misaligned accesses in plain mode
        wr(0, 9'h011, 2'd1, 32'hFFFFFFFF, 1, "R9 misaligned half write");
        rd(0, 9'h010, 2'd2, 32'h77885ED4, 0, "R9 misaligned write no effect");
        rd(0, 9'h012, 2'd2, 32'h00000000, 1, "R9 misaligned word read");
        // Known contents for the protected region
        wr(0, 9'h040, 2'd2, 32'h0, 0, "R3 clear word 16");
        wr(0, 9'h044, 2'd2, 32'h0, 0, "R3 clear word 17");
        wr(0, 9'h048, 2'd2, 32'h0, 0, "R3 clear word 18");
        // R4: protected byte writes land as data/inverse pairs
        wr(1, 9'h020, 2'd0, 32'h0000003C, 0, "R4 even byte write");
        rd(0, 9'h040, 2'd2, 32'h0000C33C, 0, "R4 even byte layout");
        wr(1, 9'h021, 2'd0, 32'h00005A00, 0, "R4 odd byte write");
        rd(0, 9'h040, 2'd2, 32'hA55AC33C, 0, "R4 odd byte layout");
        // R5: protected reads of good pairs
        rd(1, 9'h021, 2'd0, 32'h00005A00, 0, "R5 odd byte read");
        rd(1, 9'h020, 2'd0, 32'h0000003C, 0, "R5 even byte read");
        rd(1, 9'h020, 2'd1, 32'h00005A3C, 0, "R5 half read");
        // R10 / R4: protected half-word
        wr(1, 9'h022, 2'd1, 32'h12340000, 0, "R4 half write");
        rd(1, 9'h022, 2'd1, 32'h12340000, 0, "R10 half read good");
        rd(0, 9'h044, 2'd2, 32'hED12CB34, 0, "R4 half layout");
        // R7: word accesses neutralised
        wr(1, 9'h020, 2'd2, 32'hFFFFFFFF, 0, "R7 word write dropped");
        rd(1, 9'h020, 2'd1, 32'h00005A3C, 0, "R7 word write no effect");
        rd(1, 9'h020, 2'd2, 32'h00000000, 0, "R7 word read zero");
        // R8: reserved half
        wr(1, 9'h120, 2'd0, 32'h000000FF, 1, "R8 reserved write");
        rd(1, 9'h020, 2'd0, 32'h0000003C, 0, "R8 reserved write no effect");
        rd(1, 9'h120, 2'd0, 32'h00000000, 1, "R8 reserved byte read");
        rd(1, 9'h124, 2'd2, 32'h00000000, 1, "R8 reserved word read");
        // R9: protected misaligned half
        wr(1, 9'h021, 2'd1, 32'h0000FFFF, 1, "R9 protected misaligned half");
        rd(1, 9'h020, 2'd1, 32'h00005A3C, 0, "R9 protected misaligned no effect");
        // R2: back-to-back write then read of the same word
        wr(1, 9'h024, 2'd0, 32'h00000081, 0, "R2 write before read");
        rd(1, 9'h024, 2'd0, 32'h00000081, 0, "R2 read after write");
        rd(0, 9'h048, 2'd2, 32'h00007E81, 0, "R4 pair in word 18");
        // R6: corrupt the inverse of byte 0x20 in plain mode
        wr(0, 9'h041, 2'd0, 32'h00003C00, 0, "R6 corrupt inverse");
        rd(1, 9'h020, 2'd0, 32'h00000000, 1, "R6 mismatch byte read");
        rd(1, 9'h021, 2'd0, 32'h00005A00, 0, "R6 neighbour byte intact");
        rd(1, 9'h020, 2'd1, 32'h00000000, 1, "R10 low pair mismatch");
        // R10: corrupt the upper inverse of word 17
        wr(0, 9'h047, 2'd0, 32'h00000000, 0, "R10 corrupt upper inverse");
        rd(1, 9'h022, 2'd1, 32'h00000000, 1, "R10 high pair mismatch");
        rd(1, 9'h022, 2'd0, 32'h00340000, 0, "R10 low byte still good");
        rd(1, 9'h023, 2'd0, 32'h00000000, 1, "R6 odd byte mismatch");

        idle();
        repeat (3) @(negedge clk);
        n_cmp++;
        if (exp_q.size() != 0) begin
            n_bad++;
            $display("FAIL R2: %0d responses missing expected 0", exp_q.size());
        end
        report();
        $finish;
    end

endmodule